// File: doc/BRIEF.md
# Receive Ring Buffer Packet Writer

This block takes receive frames that address filtering has already accepted and stores them in a circular packet buffer. The buffer is divided into 256-byte pages and runs from a programmable start page up to, but not including, a programmable stop page. Every stored frame takes a fresh page and begins with a 4-byte header. The frame bytes follow the header. Frames shorter than the Ethernet minimum are padded with zero bytes.

The block owns the current-page pointer. That pointer is the page where the next frame will be placed, and the host may also load it. The host frees pages by moving the boundary page. A new frame is accepted only when the free space, counted in whole pages, can hold a maximum-size frame plus its header. A frame is refused outright while the receiver is stopped.

When a frame is fully in memory, the block does three things: it advances the current page to the pre-computed next page, it copies the header status byte into a receive-status register, and it pulses a receive-interrupt request.

The frame input is a byte stream with start, valid and last markers. A ready output holds the source off while padding and header bytes are written. Memory is reached through a registered byte-wide write port.

Top module: `rxring_writer`

## Requirements
- R1: When `stopped` is high at the first byte of a frame, the whole frame is discarded: no memory write, no `rx_irq`, and `cur_pg` is unchanged.
- R2: Free space in bytes is 256·(`bnd_pg` − `cur_pg`) when `cur_pg` < `bnd_pg`. Otherwise it is 256·(`stop_pg` − `start_pg`) − 256·(`cur_pg` − `bnd_pg`). A frame is discarded with no writes when this is below 1518 bytes. A free space of 5 pages is refused and 6 pages is accepted.
- R3: A frame of fewer than 60 bytes is stored as 60 bytes, with zero bytes after the last real byte.
- R4: Header byte 2 holds bits 7:0 of the stored length and header byte 3 holds bits 15:8. The stored length is the padded frame length plus 4.
- R5: The next page is `cur_pg` + floor((stored length + 4 + 255) / 256). When that result is at or above `stop_pg`, (`stop_pg` − `start_pg`) is subtracted. Header byte 1 holds the next page.
- R6: Header byte 0 is the status byte. Bit 0 is always 1. Bit 5 copies bit 0 of the frame's first byte. All other bits are 0. After the frame, `rx_status` holds the same byte.
- R7: The header occupies byte offsets 0..3 of page `cur_pg`, and frame bytes start at offset 4. When the write address reaches `stop_pg`·256, it continues at `start_pg`·256.
- R8: After the last header byte, `cur_pg` takes the next page, and `rx_irq` is high for exactly one cycle per stored frame. `cur_pg` changes at no other time except on a host load.
- R9: After reset, `cur_pg` = 0, `rx_status` = 0, `rx_irq` = 0, `mem_we` = 0 and `in_ready` = 1.
- R10: A cycle with `cur_wr_en` high loads `cur_wr_data` into `cur_pg` at the next clock edge.
- R11: Every memory write lands in a page p with `start_pg` ≤ p < `stop_pg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stopped | input | 1 | Receiver stopped; new frames are refused |
| start_pg | input | PAGE_BITS | First page of the ring |
| stop_pg | input | PAGE_BITS | Page just past the end of the ring |
| bnd_pg | input | PAGE_BITS | Host boundary page; pages from here on are still owned by the host |
| cur_wr_en | input | 1 | Host load strobe for the current page |
| cur_wr_data | input | PAGE_BITS | Value loaded into the current page |
| in_valid | input | 1 | Frame byte present |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Block takes the byte this cycle |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | PAGE_BITS+8 | Buffer byte address (page, offset) |
| mem_wdata | output | 8 | Buffer write data |
| cur_pg | output | PAGE_BITS | Current page pointer |
| rx_status | output | 8 | Status byte of the last stored frame |
| rx_irq | output | 1 | One-cycle receive-interrupt request |

## Verification
The assertions rely on three assumptions about the inputs:
- The ring registers are sane: `start_pg` < `stop_pg`, and both `cur_pg` and `bnd_pg` lie inside the ring.
- `in_sof` marks only the first byte of a frame.
- No frame is longer than 1514 bytes.

The host-side registers are not changed while a frame is in flight.

The stimulus stays within these limits. It programs one fixed ring, places the boundary at a chosen page distance from the current page, and draws random lengths only between 1 and 1514. It loads the current page only between frames, and only with an in-ring value, including the last page so that both the data and the next-page pointer wrap.

// File: rtl/rxr_pkg.sv
// Package: shared types and constants of the receive ring writer.
package rxr_pkg;

    // Writer sequencing: idle, copying frame bytes, zero padding, header, discarding.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_PAD,
        ST_HDR,
        ST_DROP
    } rxw_state_e;

    // Status byte bits.
    localparam logic [7:0] RXST_OK    = 8'h01;
    localparam logic [7:0] RXST_GROUP = 8'h20;

endpackage

// File: rtl/rxr_space_chk.sv
// Module: rxr_space_chk
// Decides whether the ring has room for a worst-case frame plus its header.
// Works in page units shifted to bytes. It assumes the start page is below the
// stop page and that the current and boundary pages lie inside the ring.
// current == boundary counts as an empty ring.
module rxr_space_chk #(
    parameter int PAGE_BITS = 8,
    parameter int NEED      = 1518
) (
    input  logic [PAGE_BITS-1:0] cur,
    input  logic [PAGE_BITS-1:0] bnd,
    input  logic [PAGE_BITS-1:0] start,
    input  logic [PAGE_BITS-1:0] stop,
    output logic                 has_room
);
    localparam int BW = PAGE_BITS + 9;

    logic [BW-1:0] ring_b;
    logic [BW-1:0] used_b;
    logic [BW-1:0] avail_b;

    // Free bytes between the current page and the boundary page.
    always_comb begin
        ring_b = {1'b0, PAGE_BITS'(stop - start), 8'h00};
        used_b = {1'b0, PAGE_BITS'(cur - bnd), 8'h00};
        if (cur < bnd) begin
            avail_b = {1'b0, PAGE_BITS'(bnd - cur), 8'h00};
        end else begin
            avail_b = ring_b - used_b;
        end
        has_room = (avail_b >= BW'(NEED));
    end

endmodule

// File: rtl/rxr_next_pg.sv
// Module: rxr_next_pg
// Computes the page that follows a stored frame. Pages are rounded up over the
// stored length plus the header, and the result wraps from the stop page back
// into the ring. It assumes base lies in [start, stop).
module rxr_next_pg #(
    parameter int PAGE_BITS = 8,
    parameter int LW        = 11,
    parameter int HDR_BYTES = 4
) (
    input  logic [PAGE_BITS-1:0] base,
    input  logic [PAGE_BITS-1:0] start,
    input  logic [PAGE_BITS-1:0] stop,
    input  logic [LW-1:0]        store_len,
    output logic [PAGE_BITS-1:0] nxt
);
    localparam int SW = LW + 2;
    localparam int ROUND = HDR_BYTES + 255;

    logic [SW-1:0]        span;
    logic [PAGE_BITS:0]   sum;

    // Round the occupied bytes up to pages, then wrap at the stop page.
    always_comb begin
        span = SW'(store_len) + SW'(ROUND);
        sum  = (PAGE_BITS + 1)'(base) + (PAGE_BITS + 1)'(span >> 8);
        if (sum >= {1'b0, stop}) begin
            nxt = PAGE_BITS'(sum - (PAGE_BITS + 1)'(PAGE_BITS'(stop - start)));
        end else begin
            nxt = PAGE_BITS'(sum);
        end
    end

endmodule

// File: rtl/rxr_addr_step.sv
// Module: rxr_addr_step
// Advances a byte address by one. On reaching the first byte of the stop page,
// it wraps to the first byte of the start page.
module rxr_addr_step #(
    parameter int PAGE_BITS = 8,
    parameter int AW        = PAGE_BITS + 8
) (
    input  logic [AW-1:0]        addr,
    input  logic [PAGE_BITS-1:0] start,
    input  logic [PAGE_BITS-1:0] stop,
    output logic [AW-1:0]        nxt
);
    logic [AW-1:0] inc;

    // Increment, then fold the stop boundary onto the start page.
    always_comb begin
        inc = addr + AW'(1);
        nxt = (inc == {stop, 8'h00}) ? {start, 8'h00} : inc;
    end

endmodule

// File: rtl/rxring_writer.sv
// Module: rxring_writer
// Stores accepted receive frames into a paged circular buffer.
// Frame bytes go to offset 4 of the current page and onward, wrapping at the stop page.
// Short frames are zero padded. A 4-byte header (status, next page, length low,
// length high) is then written at offset 0. After that the current page advances,
// the status register loads, and a one-cycle interrupt request fires.
// Assumptions: in_sof marks only the first byte of a frame, no frame exceeds
// MAX_FRAME bytes, and the ring registers are sane and steady during a frame.
module rxring_writer #(
    parameter int PAGE_BITS = 8,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stopped,
    input  logic [PAGE_BITS-1:0]   start_pg,
    input  logic [PAGE_BITS-1:0]   stop_pg,
    input  logic [PAGE_BITS-1:0]   bnd_pg,
    input  logic                   cur_wr_en,
    input  logic [PAGE_BITS-1:0]   cur_wr_data,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic                   in_eof,
    input  logic [7:0]             in_data,
    output logic                   in_ready,
    output logic                   mem_we,
    output logic [PAGE_BITS+7:0]   mem_addr,
    output logic [7:0]             mem_wdata,
    output logic [PAGE_BITS-1:0]   cur_pg,
    output logic [7:0]             rx_status,
    output logic                   rx_irq
);
    import rxr_pkg::*;

    localparam int AW        = PAGE_BITS + 8;
    localparam int HDR_BYTES = 4;
    localparam int NEED      = MAX_FRAME + HDR_BYTES;
    localparam int LW        = $clog2(NEED + 1);

    rxw_state_e           state_q;
    logic [PAGE_BITS-1:0] cur_q;
    logic [PAGE_BITS-1:0] base_q;
    logic [AW-1:0]        wr_addr_q;
    logic [LW-1:0]        len_q;
    logic [1:0]           hidx_q;
    logic                 group_q;
    logic                 mem_we_q;
    logic [AW-1:0]        mem_addr_q;
    logic [7:0]           mem_wdata_q;
    logic [7:0]           status_q;
    logic                 irq_q;

    logic                 has_room;
    logic [PAGE_BITS-1:0] nxt_pg;
    logic [AW-1:0]        addr_nxt;
    logic [LW-1:0]        len_inc;
    logic [LW-1:0]        store_len;
    logic [7:0]           stat_byte;
    logic [7:0]           hdr_byte;

    rxr_space_chk #(.PAGE_BITS(PAGE_BITS), .NEED(NEED)) u_space (
        .cur      (cur_q),
        .bnd      (bnd_pg),
        .start    (start_pg),
        .stop     (stop_pg),
        .has_room (has_room)
    );

    rxr_next_pg #(.PAGE_BITS(PAGE_BITS), .LW(LW), .HDR_BYTES(HDR_BYTES)) u_next (
        .base      (base_q),
        .start     (start_pg),
        .stop      (stop_pg),
        .store_len (store_len),
        .nxt       (nxt_pg)
    );

    rxr_addr_step #(.PAGE_BITS(PAGE_BITS), .AW(AW)) u_step (
        .addr  (wr_addr_q),
        .start (start_pg),
        .stop  (stop_pg),
        .nxt   (addr_nxt)
    );

    // Frame length bookkeeping and the header byte selected by hidx_q.
    always_comb begin
        len_inc   = len_q + LW'(1);
        store_len = len_q + LW'(HDR_BYTES);
        stat_byte = RXST_OK | (group_q ? RXST_GROUP : 8'h00);
        case (hidx_q)
            2'd0:    hdr_byte = stat_byte;
            2'd1:    hdr_byte = 8'(nxt_pg);
            2'd2:    hdr_byte = store_len[7:0];
            default: hdr_byte = 8'(store_len >> 8);
        endcase
    end

    // Source is held off only while padding or the header is being written.
    assign in_ready = (state_q == ST_IDLE) || (state_q == ST_DATA) || (state_q == ST_DROP);

    // Main sequencer: accept or refuse, copy, pad, write header, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cur_q       <= '0;
            base_q      <= '0;
            wr_addr_q   <= '0;
            len_q       <= '0;
            hidx_q      <= '0;
            group_q     <= 1'b0;
            mem_we_q    <= 1'b0;
            mem_addr_q  <= '0;
            mem_wdata_q <= '0;
            status_q    <= '0;
            irq_q       <= 1'b0;
        end else begin
            mem_we_q <= 1'b0;
            irq_q    <= 1'b0;
            if (cur_wr_en) begin
                cur_q <= cur_wr_data;
            end
            case (state_q)
                ST_IDLE: begin
                    hidx_q <= '0;
                    if (in_valid && in_sof) begin
                        if (stopped || !has_room) begin
                            state_q <= in_eof ? ST_IDLE : ST_DROP;
                        end else begin
                            base_q      <= cur_q;
                            group_q     <= in_data[0];
                            mem_we_q    <= 1'b1;
                            mem_addr_q  <= {cur_q, 8'(HDR_BYTES)};
                            mem_wdata_q <= in_data;
                            wr_addr_q   <= {cur_q, 8'(HDR_BYTES + 1)};
                            len_q       <= LW'(1);
                            if (in_eof) begin
                                state_q <= (MIN_FRAME > 1) ? ST_PAD : ST_HDR;
                            end else begin
                                state_q <= ST_DATA;
                            end
                        end
                    end
                end
                ST_DATA: begin
                    if (in_valid) begin
                        mem_we_q    <= 1'b1;
                        mem_addr_q  <= wr_addr_q;
                        mem_wdata_q <= in_data;
                        wr_addr_q   <= addr_nxt;
                        len_q       <= len_inc;
                        if (in_eof) begin
                            state_q <= (len_inc < LW'(MIN_FRAME)) ? ST_PAD : ST_HDR;
                        end
                    end
                end
                ST_PAD: begin
                    mem_we_q    <= 1'b1;
                    mem_addr_q  <= wr_addr_q;
                    mem_wdata_q <= 8'h00;
                    wr_addr_q   <= addr_nxt;
                    len_q       <= len_inc;
                    if (len_inc >= LW'(MIN_FRAME)) begin
                        state_q <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    mem_we_q    <= 1'b1;
                    mem_addr_q  <= {base_q, 8'(hidx_q)};
                    mem_wdata_q <= hdr_byte;
                    hidx_q      <= hidx_q + 2'd1;
                    if (hidx_q == 2'd3) begin
                        cur_q    <= nxt_pg;
                        status_q <= stat_byte;
                        irq_q    <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                ST_DROP: begin
                    if (in_valid && in_eof) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_we    = mem_we_q;
    assign mem_addr  = mem_addr_q;
    assign mem_wdata = mem_wdata_q;
    assign cur_pg    = cur_q;
    assign rx_status = status_q;
    assign rx_irq    = irq_q;

endmodule

// File: rtl/rxr_checker.sv
// Module: rxr_checker
// Temporal checks on the ports of rxring_writer, attached by bind below.
// Relies on the input assumptions stated in the writer's header.
module rxr_checker #(
    parameter int PAGE_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 stopped,
    input logic [PAGE_BITS-1:0] start_pg,
    input logic [PAGE_BITS-1:0] stop_pg,
    input logic                 cur_wr_en,
    input logic                 in_valid,
    input logic                 in_sof,
    input logic                 in_ready,
    input logic                 mem_we,
    input logic [PAGE_BITS+7:0] mem_addr,
    input logic [PAGE_BITS-1:0] cur_pg,
    input logic [7:0]           rx_status,
    input logic                 rx_irq
);
    AST_STOPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_sof && stopped) |=> !mem_we); // R1

    AST_WRITE_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[PAGE_BITS+7:8] >= start_pg && mem_addr[PAGE_BITS+7:8] < stop_pg)); // R11

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq); // R8

    AST_CUR_MOVES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_pg != $past(cur_pg)) |-> (rx_irq || $past(cur_wr_en))); // R8

    AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_status[0] && ((rx_status & 8'hDE) == 8'h00))); // R6

endmodule

bind rxring_writer rxr_checker #(.PAGE_BITS(PAGE_BITS)) u_rxr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .stopped   (stopped),
    .start_pg  (start_pg),
    .stop_pg   (stop_pg),
    .cur_wr_en (cur_wr_en),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_ready  (in_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .cur_pg    (cur_pg),
    .rx_status (rx_status),
    .rx_irq    (rx_irq)
);

// File: tb/test_rxring_writer.sv
// Bench for rxring_writer: directed corner frames plus seeded random lengths.
// Each result is compared with a model of the ring held in bench functions.
module test_rxring_writer;

    localparam int PB    = 8;
    localparam int RSTRT = 'h40;
    localparam int RSTOP = 'h60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stopped = 1'b0;
    logic [PB-1:0] start_pg = PB'(RSTRT);
    logic [PB-1:0] stop_pg = PB'(RSTOP);
    logic [PB-1:0] bnd_pg = PB'(RSTRT);
    logic          cur_wr_en = 1'b0;
    logic [PB-1:0] cur_wr_data = '0;
    logic          in_valid = 1'b0;
    logic          in_sof = 1'b0;
    logic          in_eof = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready;
    logic          mem_we;
    logic [PB+7:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [PB-1:0] cur_pg;
    logic [7:0]    rx_status;
    logic          rx_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    int irq_cnt = 0;
    int out_ring = 0;
    int mem [int];
    logic [7:0] fr [0:1513];

    always #2 clk = ~clk;

    rxring_writer #(.PAGE_BITS(PB)) i_rxring_writer (
        .clk(clk), .rst_n(rst_n), .stopped(stopped),
        .start_pg(start_pg), .stop_pg(stop_pg), .bnd_pg(bnd_pg),
        .cur_wr_en(cur_wr_en), .cur_wr_data(cur_wr_data),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_pg(cur_pg), .rx_status(rx_status), .rx_irq(rx_irq)
    );

    // Record buffer writes and interrupt pulses as seen at each edge.
    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            mem[int'(mem_addr)] = int'(mem_wdata);
            wr_cnt++;
            if (int'(mem_addr[PB+7:8]) < RSTRT || int'(mem_addr[PB+7:8]) >= RSTOP) out_ring++;
        end
        if (rst_n && rx_irq) irq_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic int padded(input int n);
        return (n < 60) ? 60 : n;
    endfunction

    function automatic int exp_next(input int cur, input int n);
        int nx = cur + (padded(n) + 4 + 4 + 255) / 256;
        if (nx >= RSTOP) nx -= (RSTOP - RSTRT);
        return nx;
    endfunction

    function automatic int rd(input int a);
        return mem.exists(a) ? mem[a] : -1;
    endfunction

    // Boundary placed k pages of free space ahead of the current page (k=0: ring empty).
    task automatic set_room(input int k);
        bnd_pg = PB'(RSTRT + ((int'(cur_pg) - RSTRT + k) % (RSTOP - RSTRT)));
    endtask

    task automatic load_cur(input int pg);
        @(negedge clk); cur_wr_en = 1'b1; cur_wr_data = PB'(pg);
        @(negedge clk); cur_wr_en = 1'b0;
    endtask

    task automatic fill(input int n, input bit grp);
        for (int i = 0; i < n; i++) fr[i] = 8'($urandom_range(1, 255));
        fr[0][0] = grp;
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == n - 1); in_data = fr[i];
            forever begin
                @(posedge clk);
                if (in_ready) break;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    // Send a frame that must be stored and compare the ring contents with the model.
    task automatic stored_frame(input int n, input bit grp);
        int cur0 = int'(cur_pg);
        int irq0;
        int nx = exp_next(cur0, n);
        int L = padded(n);
        int a = cur0 * 256 + 4;
        int bad = 0;
        int first_a = 0;
        int first_v = 0;
        int first_e = 0;
        int waited = 0;
        int st = 1 | (grp ? 'h20 : 0);
        mem.delete();
        irq0 = irq_cnt;
        fill(n, grp);
        send(n);
        while (irq_cnt == irq0 && waited < 200) begin @(negedge clk); waited++; end
        @(negedge clk);
        chk(irq_cnt == irq0 + 1, "R8 one interrupt per frame", irq_cnt - irq0, 1);
        chk(rd(cur0 * 256) == st, "R6 header status byte", rd(cur0 * 256), st);
        chk(rd(cur0 * 256 + 1) == nx, "R5 header next page", rd(cur0 * 256 + 1), nx);
        chk(rd(cur0 * 256 + 2) == ((L + 4) & 'hff), "R4 length low", rd(cur0 * 256 + 2), (L + 4) & 'hff);
        chk(rd(cur0 * 256 + 3) == ((L + 4) >> 8), "R4 length high", rd(cur0 * 256 + 3), (L + 4) >> 8);
        for (int i = 0; i < L; i++) begin
            int e = (i < n) ? int'(fr[i]) : 0;
            if (rd(a) != e && bad == 0) begin first_a = a; first_v = rd(a); first_e = e; end
            if (rd(a) != e) bad++;
            a++;
            if (a == RSTOP * 256) a = RSTRT * 256;
        end
        if (n < 60) chk(bad == 0, "R3 data with zero pad", first_v, first_e);
        else        chk(bad == 0, "R7 data after header with wrap", first_v, first_e);
        if (bad != 0) $display("  first mismatch at address 0x%0h", first_a);
        chk(int'(cur_pg) == nx, "R8 current page advanced", int'(cur_pg), nx);
        chk(int'(rx_status) == st, "R6 status register", int'(rx_status), st);
    endtask

    // Send a frame that must be refused and confirm nothing moved.
    task automatic refused_frame(input int n, input string req);
        int cur0 = int'(cur_pg);
        int w0 = wr_cnt;
        int i0 = irq_cnt;
        fill(n, 1'b0);
        send(n);
        repeat (80) @(negedge clk);
        chk(wr_cnt == w0, {req, " no writes"}, wr_cnt - w0, 0);
        chk(irq_cnt == i0, {req, " no interrupt"}, irq_cnt - i0, 0);
        chk(int'(cur_pg) == cur0, {req, " current page kept"}, int'(cur_pg), cur0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R9 reset state
        chk(cur_pg == '0, "R9 cur_pg after reset", int'(cur_pg), 0);
        chk(rx_status == 8'h00, "R9 rx_status after reset", int'(rx_status), 0);
        chk(!rx_irq && !mem_we, "R9 irq and write idle", int'({rx_irq, mem_we}), 0);
        chk(in_ready, "R9 ready after reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 host load of the current page
        load_cur(RSTRT);
        chk(int'(cur_pg) == RSTRT, "R10 host load", int'(cur_pg), RSTRT);
        set_room(0);

        // Directed lengths around the pad threshold and the maximum.
        stored_frame(1, 1'b0);
        stored_frame(10, 1'b1);
        stored_frame(59, 1'b0);
        stored_frame(60, 1'b1);
        stored_frame(61, 1'b0);
        stored_frame(1514, 1'b0);
        set_room(0);

        // R7 / R5 wrap: start on the last page of the ring.
        load_cur(RSTOP - 1);
        set_room(0);
        stored_frame(600, 1'b1);

        // R1 stopped receiver
        stopped = 1'b1;
        refused_frame(100, "R1 stopped");
        stopped = 1'b0;

        // R2 space threshold: 5 pages refused, 6 pages accepted.
        set_room(5);
        refused_frame(70, "R2 five free pages");
        set_room(6);
        stored_frame(1514, 1'b0);
        set_room(0);

        // Random lengths with the host freeing everything between frames.
        for (int k = 0; k < 25; k++) begin
            int n = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 64) : $urandom_range(1, 1514);
            stored_frame(n, 1'($urandom_range(0, 1)));
            set_room(0);
        end

        chk(out_ring == 0, "R11 writes inside ring", out_ring, 0);
        report();
    end

endmodule